// File: doc/BRIEF.md
# Daisy-Chain Device Select

This block sits in one chip of a daisy chain of content-addressable memories that share a host bus. It holds two 16-bit registers. The page register holds this chip's own identity in the chain. The select register holds the identity the host wants to talk to. Each register is loaded in two steps. The host first issues an instruction that names the register as the target. It then issues one command-write cycle that carries the value. The instruction decoder is not part of this block: the instructions arrive as single-cycle decoded strobes.

The block compares the two registers. From that comparison it reports whether the chip is selected, and whether it is selected on its own or through the all-ones broadcast value. It also tells the rest of the chip which cycle types it may serve. Writes are served whenever the chip is selected. Reads are served only when the chip is selected on its own, because several chips answering at once would collide on the bus.

Page loading moves down the chain. The chip takes page loads while its chain input is high and it has not yet passed loading on. A "select next" instruction passes loading on and raises the chain output, which feeds the chain input of the next chip.

Top module: `chain_sel`

## Requirements
- R1: While `rstN` is low, the page and select registers are 0000h and `selected`, `broadcast`, `readAllowed`, `writeAllowed` and `chainOut` are all 0.
- R2: A `cmdWrite` cycle that follows a `tgtPage` strobe loads `wrData` into the page register, provided `chainIn` is 1 and `chainOut` is 0.
- R3: A page write whose value is FFFFh is rejected, and the page register keeps its old value.
- R4: A `cmdWrite` cycle that follows a `tgtSelect` strobe loads `wrData` into the select register. The new value appears on `selRdData` right after the clock edge that captures the write.
- R5: `selected` is 1 when the select register equals the page register. The outputs follow a register change one clock later than `selRdData` does.
- R6: When the select register holds FFFFh, both `selected` and `broadcast` are 1. Otherwise `broadcast` is 0.
- R7: `writeAllowed` equals `selected`. `readAllowed` is 1 only when the chip is selected and `broadcast` is 0.
- R8: A `swReset` pulse changes neither register, and it changes none of the outputs.
- R9: A `selNext` strobe that arrives while `chainIn` is 1 sets `chainOut` to 1. `chainOut` then stays at 1 until a hardware reset, and page writes made after that point are ignored.
- R10: A `cmdWrite` cycle with no target pending changes no register. Each target strobe is used up by the first `cmdWrite` cycle that follows it.
- R11: A page write made while `chainIn` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| swReset | input | 1 | Software reset pulse from the control register (has no effect here) |
| tgtPage | input | 1 | Decoded strobe: the next command write goes to the page register |
| tgtSelect | input | 1 | Decoded strobe: the next command write goes to the select register |
| selNext | input | 1 | Decoded strobe: pass page loading on to the next chip |
| cmdWrite | input | 1 | Command-write cycle strobe |
| wrData | input | 16 | Command-write data |
| chainIn | input | 1 | Chain input from the previous chip (1 = this chip may take page loads) |
| chainOut | output | 1 | Chain output to the next chip |
| selRdData | output | 16 | Read-back value of the select register |
| selected | output | 1 | The chip is selected (registered) |
| broadcast | output | 1 | The chip is selected through the broadcast value (registered) |
| readAllowed | output | 1 | Command and data reads may be served (registered) |
| writeAllowed | output | 1 | Command and data writes may be served (registered) |

## Verification
The assertions watch the port-level rules on every cycle:
- the broadcast flags that follow a read-back of all ones,
- the tie between writes and selection,
- the absence of reads during broadcast,
- the chain output that never drops once set,
- a select register that stays fixed when no command write occurs.

Only the bench scenarios can show:
- which target a write reaches, and that a target is used up after one write,
- the rejection of the all-ones page value,
- the effect of the chain input on page loading,
- the one-cycle lag of the outputs.

These depend on ordered sequences of instructions.

// File: rtl/chain_sel_pkg.sv
package chain_sel_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_PAGE   = 2'd1,
    TGT_SELECT = 2'd2
  } target_e;

  typedef struct packed {
    logic loadPage;
    logic loadSelect;
    logic passOn;
  } ctrl_strobes_t;
endpackage

// File: rtl/chain_sel_ctrl.sv
module chain_sel_ctrl
  import chain_sel_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tgtPage,
  input  logic          tgtSelect,
  input  logic          selNext,
  input  logic          cmdWrite,
  input  logic          chainIn,
  output ctrl_strobes_t strobes,
  output logic          chainOut
);
  target_e target;
  logic    passed;
  logic    loadingHere;

  // This chip takes page loads between the chain hand-over and its own selNext.
  assign loadingHere = chainIn && !passed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= TGT_NONE;
    end else if (tgtPage) begin
      target <= TGT_PAGE;
    end else if (tgtSelect) begin
      target <= TGT_SELECT;
    end else if (cmdWrite) begin
      target <= TGT_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passed <= 1'b0;
    end else if (strobes.passOn) begin
      passed <= 1'b1;
    end
  end

  always_comb begin
    strobes.loadPage   = cmdWrite && (target == TGT_PAGE) && loadingHere;
    strobes.loadSelect = cmdWrite && (target == TGT_SELECT);
    strobes.passOn     = selNext && loadingHere;
  end

  assign chainOut = passed;
endmodule

// File: rtl/chain_sel_dp.sv
module chain_sel_dp
  import chain_sel_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic [ID_W-1:0]   wrData,
  output logic [ID_W-1:0]   selRdData,
  output logic              selected,
  output logic              broadcast,
  output logic              readAllowed,
  output logic              writeAllowed
);
  localparam logic [ID_W-1:0] ALL_ONES = {ID_W{1'b1}};

  logic [ID_W-1:0] pageId;
  logic [ID_W-1:0] selId;
  logic            idMatch;
  logic            isBcast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageId <= '0;
    end else if (strobes.loadPage && (wrData != ALL_ONES)) begin
      pageId <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selId <= '0;
    end else if (strobes.loadSelect) begin
      selId <= wrData;
    end
  end

  assign idMatch = (selId == pageId);
  assign isBcast = (selId == ALL_ONES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected     <= 1'b0;
      broadcast    <= 1'b0;
      readAllowed  <= 1'b0;
      writeAllowed <= 1'b0;
    end else begin
      selected     <= idMatch || isBcast;
      broadcast    <= isBcast;
      readAllowed  <= idMatch && !isBcast;
      writeAllowed <= idMatch || isBcast;
    end
  end

  assign selRdData = selId;
endmodule

// File: rtl/chain_sel.sv
module chain_sel
  import chain_sel_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            swReset,
  input  logic            tgtPage,
  input  logic            tgtSelect,
  input  logic            selNext,
  input  logic            cmdWrite,
  input  logic [ID_W-1:0] wrData,
  input  logic            chainIn,
  output logic            chainOut,
  output logic [ID_W-1:0] selRdData,
  output logic            selected,
  output logic            broadcast,
  output logic            readAllowed,
  output logic            writeAllowed
);
  ctrl_strobes_t strobes;
  logic          swResetUnused;

  // The software reset leaves the identity registers alone by design.
  assign swResetUnused = swReset;

  chain_sel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tgtPage   (tgtPage),
    .tgtSelect (tgtSelect),
    .selNext   (selNext),
    .cmdWrite  (cmdWrite),
    .chainIn   (chainIn),
    .strobes   (strobes),
    .chainOut  (chainOut)
  );

  chain_sel_dp #(.ID_W(ID_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (wrData),
    .selRdData    (selRdData),
    .selected     (selected),
    .broadcast    (broadcast),
    .readAllowed  (readAllowed),
    .writeAllowed (writeAllowed)
  );
endmodule

// File: rtl/chain_sel_chk.sv
module chain_sel_chk #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            swReset,
  input logic            cmdWrite,
  input logic            chainOut,
  input logic [ID_W-1:0] selRdData,
  input logic            selected,
  input logic            broadcast,
  input logic            readAllowed,
  input logic            writeAllowed
);
  // R6
  bcast_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selRdData == {ID_W{1'b1}}) |=> (broadcast && selected));

  // R7
  write_follows_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeAllowed == selected);

  // R7
  no_bcast_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    broadcast |-> !readAllowed);

  // R9
  chain_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |=> chainOut);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrite |=> $stable(selRdData));

  // R8
  swreset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swReset && !cmdWrite) |=> $stable(selRdData));
endmodule

bind chain_sel chain_sel_chk #(.ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .swReset      (swReset),
  .cmdWrite     (cmdWrite),
  .chainOut     (chainOut),
  .selRdData    (selRdData),
  .selected     (selected),
  .broadcast    (broadcast),
  .readAllowed  (readAllowed),
  .writeAllowed (writeAllowed)
);

// File: tb/chain_sel_test.sv
module chain_sel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic        tgtPage = 1'b0;
  logic        tgtSelect = 1'b0;
  logic        selNext = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [15:0] wrData = '0;
  logic        chainIn = 1'b1;
  logic        chainOut;
  logic [15:0] selRdData;
  logic        selected, broadcast, readAllowed, writeAllowed;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chain_sel uut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .tgtPage(tgtPage),
    .tgtSelect(tgtSelect), .selNext(selNext), .cmdWrite(cmdWrite),
    .wrData(wrData), .chainIn(chainIn), .chainOut(chainOut),
    .selRdData(selRdData), .selected(selected), .broadcast(broadcast),
    .readAllowed(readAllowed), .writeAllowed(writeAllowed)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(string req, bit sel, bit bc, bit rd, bit wr);
    check(req, "selected", selected, sel);
    check(req, "broadcast", broadcast, bc);
    check(req, "readAllowed", readAllowed, rd);
    check(req, "writeAllowed", writeAllowed, wr);
  endtask

  task automatic pulse(string which);
    @(negedge clk);
    tgtPage   = (which == "page");
    tgtSelect = (which == "select");
    selNext   = (which == "next");
    swReset   = (which == "sw");
    @(negedge clk);
    {tgtPage, tgtSelect, selNext, swReset} = '0;
  endtask

  task automatic cmdWr(logic [15:0] v);
    @(negedge clk);
    cmdWrite = 1'b1;
    wrData = v;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic loadReg(string which, logic [15:0] v);
    pulse(which);
    cmdWr(v);
    @(negedge clk);
  endtask

  task automatic hwReset(bit chain);
    @(negedge clk);
    rstN = 1'b0;
    chainIn = chain;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    // R1: everything cleared while reset is held
    @(negedge clk);
    check("R1", "selRdData", selRdData, 16'h0000);
    checkFlags("R1", 0, 0, 0, 0);
    check("R1", "chainOut", chainOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R5: both registers are 0000h, so they match
    checkFlags("R5", 1, 0, 1, 1);
  endtask

  task automatic testPageLoad();
    loadReg("page", 16'h0005);
    pulse("select");
    cmdWr(16'h0005);
    // R4: read-back is updated, outputs still reflect the old select value
    check("R4", "selRdData", selRdData, 16'h0005);
    checkFlags("R5", 0, 0, 0, 0);
    @(negedge clk);
    checkFlags("R2", 1, 0, 1, 1);
    loadReg("select", 16'h0006);
    checkFlags("R7", 0, 0, 0, 0);
  endtask

  task automatic testRejectAllOnes();
    loadReg("page", 16'hFFFF);
    loadReg("select", 16'h0005);
    checkFlags("R3", 1, 0, 1, 1);
  endtask

  task automatic testBroadcast();
    loadReg("select", 16'hFFFF);
    check("R4", "selRdData", selRdData, 16'hFFFF);
    checkFlags("R6", 1, 1, 0, 1);
    loadReg("select", 16'h0005);
    checkFlags("R7", 1, 0, 1, 1);
  endtask

  task automatic testSwReset();
    pulse("sw");
    @(negedge clk);
    check("R8", "selRdData", selRdData, 16'h0005);
    checkFlags("R8", 1, 0, 1, 1);
  endtask

  task automatic testNoTarget();
    cmdWr(16'h0077);
    @(negedge clk);
    check("R10", "selRdData", selRdData, 16'h0005);
    checkFlags("R10", 1, 0, 1, 1);
    // the earlier select target has already been used up
    loadReg("select", 16'h0033);
    cmdWr(16'h0044);
    @(negedge clk);
    check("R10", "selRdData used-up target", selRdData, 16'h0033);
  endtask

  task automatic testChainPass();
    check("R9", "chainOut before", chainOut, 0);
    pulse("next");
    check("R9", "chainOut after", chainOut, 1);
    loadReg("page", 16'h0009);
    loadReg("select", 16'h0009);
    checkFlags("R9", 0, 0, 0, 0);
    loadReg("select", 16'h0005);
    checkFlags("R9", 1, 0, 1, 1);
    check("R9", "chainOut sticky", chainOut, 1);
  endtask

  task automatic testChainInLow();
    hwReset(1'b0);
    loadReg("page", 16'h0003);
    loadReg("select", 16'h0003);
    checkFlags("R11", 0, 0, 0, 0);
    loadReg("select", 16'h0000);
    checkFlags("R11", 1, 0, 1, 1);
    pulse("next");
    check("R11", "chainOut", chainOut, 0);
  endtask

  initial begin
    testReset();
    testPageLoad();
    testRejectAllOnes();
    testBroadcast();
    testSwReset();
    testNoTarget();
    testChainPass();
    testChainInLow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule